// File: doc/BRIEF.md
# LED-Pin GPIO Controller with PHY/GPIO Ownership Mux

This block sits between the LED pins of a five-port switch and the pads. Every port owns three LED pins, fifteen in all. Each pin has its own ownership mux. By default the pin belongs to the PHY, which drives it with its link/activity indication. Software can take the pin over through a small register bus and use it as a general-purpose input or output.

Five registers control the pins. A LED enable register gates the PHY-driven output. A mode register picks the owner. A direction register, a separate output-enable register and a data register give full control in GPIO mode. Because direction and driver enable are separate, software can set the direction, then the data value, and only then enable the driver, so the pad never glitches. Pad inputs pass through a two-flop synchronizer before software reads them.

Top module: `led_gpio_ctrl`

## Requirements
- R1: After reset, every implemented bit of the enable and mode registers is 1, and the direction, output-enable and data registers are 0. The pads therefore follow the PHY LED inputs with their drivers on.
- R2: Pin g (0..14) sits at register bit g + floor(g/3), so port n uses bits 4n+2..4n. The registers are at these word addresses: enable at 0x7d00, mode at 0x7d04 (1 = PHY, 0 = GPIO), direction at 0x7d10 (1 = output), output-enable at 0x7d14 (1 = on) and data at 0x7d18 (1 = high).
- R3: A pin in PHY mode with enable 1 has pad_oe = 1 and pad_out equal to its phy_led input.
- R4: A pin in PHY mode with enable 0 has pad_oe = 0 and pad_out = 0.
- R5: A pin in GPIO mode has pad_oe = 1 only when both its direction and its output-enable bits are 1. In that case pad_out equals its data bit; in every other case pad_out is 0.
- R6: A read of the data register returns the stored data bit for a pin that is in GPIO mode with direction 1. Every other pin returns its pad_in level through two synchronizing flops: a read captured on the second clock edge after a pad_in change still shows the old level, and a read captured on the third edge shows the new one.
- R7: The bus bits at positions 4n+3, and all bits at 19 and above, always read 0, and writes to them have no effect.
- R8: A read from any address other than the five registers returns 0. A write to such an address changes no register and no pad.
- R9: bus_rdata takes its new value on the clock edge that samples bus_re and holds that value until the next read.
- R10: The enable bit has no effect on a pin in GPIO mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Registered read data |
| phy_led | input | 15 | PHY LED indication per pin |
| pad_in | input | 15 | Pad level per pin (asynchronous) |
| pad_out | output | 15 | Value toward the pad |
| pad_oe | output | 15 | Pad driver enable |

## Verification
The pads are first checked in PHY ownership with two PHY patterns, and then with a partial enable mask, which separates the driven pins from the gated-off ones. In GPIO mode, direction, data and output-enable get different overlapping patterns. This shows that only pins with both direction and driver enabled are driven, that setting the direction alone never turns a driver on, and that clearing the enable does nothing there. A walking single-direction bit over all fifteen pins pins down the sparse bit mapping. Data reads with mixed direction and ownership tell stored values from synchronized pad levels, and the reads of stale and then fresh pad values fix the synchronizer depth. Writes of all ones, and accesses to unmapped addresses, show that unused bits and holes hold no state.

// File: rtl/led_gpio_pkg.sv
package led_gpio_pkg;
  localparam int NUM_PORTS     = 5;
  localparam int PINS_PER_PORT = 3;
  localparam int PORT_STRIDE   = 4;
  localparam int NUM_PINS      = NUM_PORTS * PINS_PER_PORT;
  localparam int DATA_W        = 32;
  localparam int ADDR_W        = 16;
  localparam int SYNC_STAGES   = 2;

  localparam logic [ADDR_W-1:0] ADR_ENABLE = 16'h7d00;
  localparam logic [ADDR_W-1:0] ADR_OWNER  = 16'h7d04;
  localparam logic [ADDR_W-1:0] ADR_DIR    = 16'h7d10;
  localparam logic [ADDR_W-1:0] ADR_DRVEN  = 16'h7d14;
  localparam logic [ADDR_W-1:0] ADR_LEVEL  = 16'h7d18;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_ENABLE, SEL_OWNER, SEL_DIR, SEL_DRVEN, SEL_LEVEL
  } reg_sel_e;

  // Bus bit that carries linear pin g: one spare bit per port group.
  function automatic int pin_bit(input int g);
    return g + (g / PINS_PER_PORT) * (PORT_STRIDE - PINS_PER_PORT);
  endfunction

  function automatic logic [DATA_W-1:0] pins_to_bus(input logic [NUM_PINS-1:0] p);
    logic [DATA_W-1:0] b;
    b = '0;
    for (int g = 0; g < NUM_PINS; g++) b[pin_bit(g)] = p[g];
    return b;
  endfunction

  function automatic logic [NUM_PINS-1:0] bus_to_pins(input logic [DATA_W-1:0] b);
    logic [NUM_PINS-1:0] p;
    for (int g = 0; g < NUM_PINS; g++) p[g] = b[pin_bit(g)];
    return p;
  endfunction

  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
    case (a)
      ADR_ENABLE: return SEL_ENABLE;
      ADR_OWNER:  return SEL_OWNER;
      ADR_DIR:    return SEL_DIR;
      ADR_DRVEN:  return SEL_DRVEN;
      ADR_LEVEL:  return SEL_LEVEL;
      default:    return SEL_NONE;
    endcase
  endfunction

  localparam logic [DATA_W-1:0] IMPL_MASK = pins_to_bus('1);
endpackage

// File: rtl/led_gpio_regs.sv
module led_gpio_regs
  import led_gpio_pkg::*;
#(
  parameter int N = NUM_PINS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  reg_sel_e     wr_sel,
  input  logic [N-1:0] wr_pins,
  output logic [N-1:0] enable_q,
  output logic [N-1:0] owner_phy_q,
  output logic [N-1:0] dir_out_q,
  output logic [N-1:0] drven_q,
  output logic [N-1:0] level_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q    <= '1;
      owner_phy_q <= '1;
      dir_out_q   <= '0;
      drven_q     <= '0;
      level_q     <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_ENABLE: enable_q    <= wr_pins;
        SEL_OWNER:  owner_phy_q <= wr_pins;
        SEL_DIR:    dir_out_q   <= wr_pins;
        SEL_DRVEN:  drven_q     <= wr_pins;
        SEL_LEVEL:  level_q     <= wr_pins;
        default: ;
      endcase
    end
  end

  // R8
  hole_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_NONE) |=>
      ($stable(enable_q) && $stable(owner_phy_q) && $stable(dir_out_q) &&
       $stable(drven_q) && $stable(level_q)));
endmodule

// File: rtl/led_gpio_sync.sv
module led_gpio_sync #(
  parameter int W      = 15,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= async_in;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/led_gpio_pinmux.sv
module led_gpio_pinmux #(
  parameter int N = 15
) (
  input  logic [N-1:0] enable,
  input  logic [N-1:0] owner_phy,
  input  logic [N-1:0] dir_out,
  input  logic [N-1:0] drven,
  input  logic [N-1:0] level,
  input  logic [N-1:0] phy_led,
  output logic [N-1:0] gpio_drive,
  output logic [N-1:0] pad_out,
  output logic [N-1:0] pad_oe
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    logic phy_drive;
    assign phy_drive     = owner_phy[i] & enable[i];
    assign gpio_drive[i] = ~owner_phy[i] & dir_out[i] & drven[i];
    assign pad_oe[i]     = phy_drive | gpio_drive[i];
    assign pad_out[i]    = (phy_drive & phy_led[i]) | (gpio_drive[i] & level[i]);
  end
endmodule

// File: rtl/led_gpio_ctrl.sv
module led_gpio_ctrl
  import led_gpio_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic                bus_we,
  input  logic                bus_re,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] phy_led,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe
);
  reg_sel_e            sel;
  logic [NUM_PINS-1:0] wr_pins;
  logic [NUM_PINS-1:0] enable_q, owner_phy_q, dir_out_q, drven_q, level_q;
  logic [NUM_PINS-1:0] pad_sync, gpio_drive, level_view, rd_pins;

  assign sel     = decode(bus_addr);
  assign wr_pins = bus_to_pins(bus_wdata);

  led_gpio_regs #(.N(NUM_PINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .wr_sel(sel), .wr_pins(wr_pins),
    .enable_q(enable_q), .owner_phy_q(owner_phy_q), .dir_out_q(dir_out_q),
    .drven_q(drven_q), .level_q(level_q)
  );

  led_gpio_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(pad_sync)
  );

  led_gpio_pinmux #(.N(NUM_PINS)) u_mux (
    .enable(enable_q), .owner_phy(owner_phy_q), .dir_out(dir_out_q),
    .drven(drven_q), .level(level_q), .phy_led(phy_led),
    .gpio_drive(gpio_drive), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // GPIO-owned output pins show the stored level, all others the pad.
  assign level_view = (~owner_phy_q & dir_out_q & level_q) |
                      (~(~owner_phy_q & dir_out_q) & pad_sync);

  always_comb begin
    case (sel)
      SEL_ENABLE: rd_pins = enable_q;
      SEL_OWNER:  rd_pins = owner_phy_q;
      SEL_DIR:    rd_pins = dir_out_q;
      SEL_DRVEN:  rd_pins = drven_q;
      SEL_LEVEL:  rd_pins = level_view;
      default:    rd_pins = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= (sel == SEL_NONE) ? '0 : pins_to_bus(rd_pins);
  end

  // R8
  hole_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && sel == SEL_NONE) |=> bus_rdata == '0);
  // R7
  spare_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~IMPL_MASK) == '0);
  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(bus_rdata));
  // R4
  phy_gated_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_phy_q & ~enable_q & pad_oe) == '0);
  // R5
  gpio_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (~owner_phy_q & ~(dir_out_q & drven_q) & pad_oe) == '0);
  // R5
  undriven_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~pad_oe) == '0);
endmodule

// File: tb/tb_led_gpio_ctrl.sv
`timescale 1ns/1ps
module tb_led_gpio_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 0, bus_re = 0;
  logic [31:0] bus_rdata;
  logic [14:0] phy_led = '0, pad_in = '0, pad_out, pad_oe;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        re_d = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  led_gpio_ctrl dut (.*);

  function automatic logic [31:0] tb_pack(input logic [14:0] p);
    logic [31:0] b = '0;
    for (int g = 0; g < 15; g++) b[(g / 3) * 4 + (g % 3)] = p[g];
    return b;
  endfunction

  // Monitor: compares each read result against the queued expectation.
  always @(posedge clk) re_d <= bus_re;
  always @(negedge clk) begin
    if (re_d && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (bus_rdata !== e) begin
        n_bad++;
        $display("FAIL %s: rdata=%h expected=%h", t, bus_rdata, e);
      end
    end
  end

  task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(posedge clk); @(negedge clk);
    bus_we = 0;
  endtask

  task automatic bus_read(input logic [15:0] a, input logic [31:0] e, input string t);
    bus_addr = a; bus_re = 1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); @(negedge clk);
    bus_re = 0;
  endtask

  task automatic check_pads(input logic [14:0] eoe, input logic [14:0] eout, input string t);
    n_cmp++;
    if (pad_oe !== eoe || pad_out !== eout) begin
      n_bad++;
      $display("FAIL %s: oe=%h out=%h expected oe=%h out=%h", t, pad_oe, pad_out, eoe, eout);
    end
  endtask

  localparam logic [31:0] ALL_IMPL = 32'h0007_7777;

  initial begin
    logic [14:0] dirp, lvl, drv, pin, msk;
    logic [31:0] held;
    dirp = 15'h0F0F; lvl = 15'h3C3C; drv = 15'h00FF; pin = 15'h5555; msk = 15'h7E3C;
    phy_led = 15'h2A5A;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 / R3: PHY owns every pin after reset
    check_pads(15'h7FFF, 15'h2A5A, "R1 reset pads");
    bus_read(16'h7d00, ALL_IMPL, "R1 enable reset");
    bus_read(16'h7d04, ALL_IMPL, "R1 mode reset");
    bus_read(16'h7d10, 32'h0, "R1 dir reset");
    bus_read(16'h7d14, 32'h0, "R1 oe reset");
    phy_led = 15'h55A3; #1;
    check_pads(15'h7FFF, 15'h55A3, "R3 phy follow");
    // R4: partial LED enable
    bus_write(16'h7d00, tb_pack(msk));
    check_pads(msk, msk & 15'h55A3, "R4 phy gated");
    bus_read(16'h7d00, tb_pack(msk), "R2 enable readback");
    // R7: spare bits hold nothing
    bus_write(16'h7d00, 32'hFFFF_FFFF);
    bus_read(16'h7d00, ALL_IMPL, "R7 spare bits");
    // R5: GPIO mode, no glitch ordering
    bus_write(16'h7d04, 32'h0);
    check_pads(15'h0, 15'h0, "R5 gpio idle");
    bus_write(16'h7d10, tb_pack(dirp));
    check_pads(15'h0, 15'h0, "R5 dir only");
    bus_write(16'h7d18, tb_pack(lvl));
    check_pads(15'h0, 15'h0, "R5 data only");
    bus_write(16'h7d14, tb_pack(drv));
    check_pads(dirp & drv, dirp & drv & lvl, "R5 driven");
    // R10: enable ignored in GPIO mode
    bus_write(16'h7d00, 32'h0);
    check_pads(dirp & drv, dirp & drv & lvl, "R10 enable ignored");
    // R6: data reads and synchronizer depth
    pad_in = pin;
    bus_read(16'h7d18, tb_pack((dirp & lvl) | (~dirp & 15'h0)), "R6 stale edge1");
    bus_read(16'h7d18, tb_pack(dirp & lvl), "R6 stale edge2");
    bus_read(16'h7d18, tb_pack((dirp & lvl) | (~dirp & pin)), "R6 fresh edge3");
    // R9: held without a strobe
    held = bus_rdata;
    repeat (3) @(negedge clk);
    n_cmp++;
    if (bus_rdata !== held) begin
      n_bad++;
      $display("FAIL R9 hold: rdata=%h expected=%h", bus_rdata, held);
    end
    // R6: PHY-owned output pins read the pad
    bus_write(16'h7d04, tb_pack(15'h0003));
    bus_read(16'h7d18, tb_pack((dirp & ~15'h0003 & lvl) | (~(dirp & ~15'h0003) & pin)),
             "R6 phy pins read pad");
    bus_write(16'h7d04, 32'h0);
    // R8: holes
    bus_write(16'h7d08, 32'h0);
    bus_write(16'h7d0c, 32'h0);
    bus_write(16'h7d1c, 32'hFFFF_FFFF);
    check_pads(dirp & drv, dirp & drv & lvl, "R8 hole write pads");
    bus_read(16'h7d10, tb_pack(dirp), "R8 dir kept");
    bus_read(16'h7d14, tb_pack(drv), "R8 oe kept");
    bus_read(16'h7d08, 32'h0, "R8 hole read");
    bus_read(16'h7d1c, 32'h0, "R8 hole read hi");
    // R7: data register spare bits
    bus_write(16'h7d10, 32'hFFFF_FFFF);
    bus_write(16'h7d18, 32'hFFFF_FFFF);
    bus_read(16'h7d18, ALL_IMPL, "R7 data spare");
    // R2: walking direction bit over the sparse map
    bus_write(16'h7d14, 32'hFFFF_FFFF);
    for (int g = 0; g < 15; g++) begin
      bus_write(16'h7d10, 32'h1 << ((g / 3) * 4 + (g % 3)));
      check_pads(15'h1 << g, 15'h1 << g, $sformatf("R2 walk pin %0d", g));
    end
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule